// File: doc/BRIEF.md
# Line-Merging Store Buffer with Fullness-Ranked Drain

This block sits between the load/store ports of a core and its L1 data cache. It holds up to eight pending write lines. Each line is a 32-byte aligned region named by its line address, which is the byte address with the low five bits dropped. Each line carries a per-byte enable mask and 32 bytes of data. Every slot can be searched at once. A write to a line already present is folded into that slot and does not use a second one.

Toward the cache, the block offers one slot per cycle. It does not pick the oldest slot. It picks the slot that has the most enabled bytes, and a complete line always comes first, so that wide bursts of narrow stores reach the cache as whole lines. Both sides use a valid/ready handshake. The write side stalls when there is no free slot or when it would merge into the slot that is leaving in the same cycle.

Top module: `l0_merge_buffer`

## Requirements
- R1: After synchronous reset, no slot is occupied, `dr_valid` is low, and a write is accepted for any line.
- R2: A write whose line matches no occupied slot takes the lowest-indexed free slot. It stores the line, the mask and the enabled bytes, and every disabled byte reads as zero. Mask bit k enables data bits [8k+7:8k].
- R3: A write whose line matches an occupied slot ORs its mask into that slot's mask and replaces only the bytes it enables. The other bytes are kept, and no slot is allocated.
- R4: When any slot is occupied, `dr_valid` is high and the drain port presents the occupied slot with the most enabled bytes. On a tie, the lowest slot index wins.
- R5: A slot whose mask is all ones is presented before any slot whose mask is partial.
- R6: A non-matching write with all eight slots occupied sees `in_ready` low. This holds even when a drain completes in the same cycle.
- R7: A drain handshake (`dr_valid` and `dr_ready` high) frees the presented slot at that clock edge. `dr_valid` is low exactly when no slot is occupied.
- R8: A matching write to the slot whose drain completes in the same cycle sees `in_ready` low. In the next cycle, the same write is treated as a miss.
- R9: A matching write to one slot and a drain of a different slot both complete in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write request present |
| in_ready | output | 1 | Write request accepted this cycle |
| in_line | input | LINE_W (27) | Line address of the write (byte address bits 31:5) |
| in_mask | input | 32 | Byte enables of the write |
| in_data | input | 256 | Write data, byte k in bits [8k+7:8k] |
| dr_valid | output | 1 | A slot is presented to the cache |
| dr_ready | input | 1 | Cache takes the presented slot |
| dr_line | output | LINE_W (27) | Line address of the presented slot |
| dr_mask | output | 32 | Merged byte enables of the presented slot |
| dr_data | output | 256 | Merged data of the presented slot |

## Verification
The hardest cases to reach are those where the merge path and the drain path meet on the same slot in the same cycle. One is a write that hits the slot leaving the buffer, which must stall and then come back as a miss. The other is a write that hits one slot while a different slot drains. Directed sequences set these up by loading a known set of lines with the drain held off, shaping the masks so that the ranking picks a known slot, and then raising `dr_ready` and the write in the same cycle. After that, a long sweep confines addresses to six lines and mixes full-line, single-quadword and scattered masks. This makes merges into nearly full slots, ties in byte count and full-buffer stalls happen often.

// File: rtl/l0mb_pkg.sv
`timescale 1ns/1ps
package l0mb_pkg;
    localparam int BYTES  = 32;
    localparam int DATA_W = BYTES * 8;
    localparam int CNT_W  = $clog2(BYTES + 1);

    // ranking key for the drain choice: completeness first, then byte count
    typedef struct packed {
        logic             full;
        logic [CNT_W-1:0] cnt;
    } rank_t;

    function automatic logic [CNT_W-1:0] popcnt(input logic [BYTES-1:0] m);
        logic [CNT_W-1:0] s;
        s = '0;
        for (int k = 0; k < BYTES; k++) s = s + CNT_W'(m[k]);
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] byte_bits(input logic [BYTES-1:0] m);
        logic [DATA_W-1:0] r;
        for (int k = 0; k < BYTES; k++) r[8*k +: 8] = {8{m[k]}};
        return r;
    endfunction
endpackage

// File: rtl/l0mb_lookup.sv
`timescale 1ns/1ps
module l0mb_lookup #(
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 27,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]             vld,
    input  logic [ENTRIES-1:0][LINE_W-1:0] lines,
    input  logic [LINE_W-1:0]              key,
    output logic                           hit,
    output logic [IDX_W-1:0]               hit_idx,
    output logic                           has_free,
    output logic [IDX_W-1:0]               free_idx
);
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        has_free = 1'b0;
        free_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld[i] && lines[i] == key) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!vld[i] && !has_free) begin
                has_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/l0mb_picker.sv
`timescale 1ns/1ps
module l0mb_picker
    import l0mb_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0]            vld,
    input  logic [ENTRIES-1:0][BYTES-1:0] masks,
    output logic                          any,
    output logic [IDX_W-1:0]              sel
);
    rank_t rk [ENTRIES];

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_rank
            assign rk[g].full = &masks[g];
            assign rk[g].cnt  = popcnt(masks[g]);
        end
    endgenerate

    always_comb begin
        rank_t best;
        any  = 1'b0;
        sel  = '0;
        best = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld[i] && (!any || (rk[i].full && !best.full) ||
                           (rk[i].full == best.full && rk[i].cnt > best.cnt))) begin
                any  = 1'b1;
                sel  = IDX_W'(i);
                best = rk[i];
            end
        end
    end
endmodule

// File: rtl/l0_merge_buffer.sv
`timescale 1ns/1ps
module l0_merge_buffer
    import l0mb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 27
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [LINE_W-1:0] in_line,
    input  logic [BYTES-1:0]  in_mask,
    input  logic [DATA_W-1:0] in_data,
    output logic              dr_valid,
    input  logic              dr_ready,
    output logic [LINE_W-1:0] dr_line,
    output logic [BYTES-1:0]  dr_mask,
    output logic [DATA_W-1:0] dr_data
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0]             vld_q;
    logic [ENTRIES-1:0][LINE_W-1:0] line_q;
    logic [ENTRIES-1:0][BYTES-1:0]  mask_q;
    logic [ENTRIES-1:0][DATA_W-1:0] data_q;

    logic             hit, has_free, drain_fire, wr_fire, stall;
    logic [IDX_W-1:0] hit_idx, free_idx, sel_idx;
    logic [DATA_W-1:0] wr_bits;

    l0mb_lookup #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_lookup (
        .vld(vld_q), .lines(line_q), .key(in_line),
        .hit(hit), .hit_idx(hit_idx), .has_free(has_free), .free_idx(free_idx)
    );

    l0mb_picker #(.ENTRIES(ENTRIES)) u_picker (
        .vld(vld_q), .masks(mask_q), .any(dr_valid), .sel(sel_idx)
    );

    assign dr_line    = line_q[sel_idx];
    assign dr_mask    = mask_q[sel_idx];
    assign dr_data    = data_q[sel_idx];
    assign drain_fire = dr_valid & dr_ready;
    // a merge into the slot leaving this cycle waits and returns as a miss
    assign stall      = hit & drain_fire & (hit_idx == sel_idx);
    assign in_ready   = hit ? !stall : has_free;
    assign wr_fire    = in_valid & in_ready;
    assign wr_bits    = byte_bits(in_mask);

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            logic do_drain, do_merge, do_alloc;
            assign do_drain = drain_fire && sel_idx == IDX_W'(g);
            assign do_merge = wr_fire && hit && hit_idx == IDX_W'(g);
            assign do_alloc = wr_fire && !hit && free_idx == IDX_W'(g);

            always_ff @(posedge clk) begin
                if (rst) begin
                    vld_q[g]  <= 1'b0;
                    line_q[g] <= '0;
                    mask_q[g] <= '0;
                    data_q[g] <= '0;
                end else begin
                    if (do_drain) vld_q[g] <= 1'b0;
                    if (do_alloc) begin
                        vld_q[g]  <= 1'b1;
                        line_q[g] <= in_line;
                        mask_q[g] <= in_mask;
                        data_q[g] <= in_data & wr_bits;
                    end
                    if (do_merge) begin
                        mask_q[g] <= mask_q[g] | in_mask;
                        data_q[g] <= (data_q[g] & ~wr_bits) | (in_data & wr_bits);
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/l0mb_checker.sv
`timescale 1ns/1ps
module l0mb_checker
    import l0mb_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int LINE_W  = 27
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           in_valid,
    input logic                           in_ready,
    input logic [LINE_W-1:0]              in_line,
    input logic                           dr_valid,
    input logic                           dr_ready,
    input logic [LINE_W-1:0]              dr_line,
    input logic [BYTES-1:0]               dr_mask,
    input logic [ENTRIES-1:0]             vld_q,
    input logic [ENTRIES-1:0][LINE_W-1:0] line_q,
    input logic [ENTRIES-1:0][BYTES-1:0]  mask_q
);
    logic hit_c, any_full;
    always_comb begin
        hit_c    = 1'b0;
        any_full = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (vld_q[i] && line_q[i] == in_line) hit_c = 1'b1;
            if (vld_q[i] && &mask_q[i]) any_full = 1'b1;
        end
    end

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!dr_valid && vld_q == '0));

    assert_alloc_grows_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !hit_c && !(dr_valid && dr_ready))
        |=> $countones(vld_q) == $past($countones(vld_q)) + 1);

    assert_merge_no_alloc_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && hit_c)
        |=> $countones(vld_q) <= $past($countones(vld_q)));

    assert_full_first_R5: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && any_full) |-> (&dr_mask));

    assert_miss_full_stall_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !hit_c && (&vld_q)) |-> !in_ready);

    assert_drain_frees_R7: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && dr_ready && !(in_valid && in_ready))
        |=> $countones(vld_q) + 1 == $past($countones(vld_q)));

    assert_valid_tracks_R7: assert property (@(posedge clk) disable iff (rst)
        dr_valid == (vld_q != '0));

    assert_merge_drain_stall_R8: assert property (@(posedge clk) disable iff (rst)
        (dr_valid && dr_ready && in_valid && in_line == dr_line) |-> !in_ready);
endmodule

bind l0_merge_buffer l0mb_checker #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_line(in_line),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_line(dr_line), .dr_mask(dr_mask),
    .vld_q(vld_q), .line_q(line_q), .mask_q(mask_q)
);

// File: tb/tb_l0_merge_buffer.sv
`timescale 1ns/1ps
module tb_l0_merge_buffer;
    localparam int N  = 8;
    localparam int LW = 27;

    logic clk = 1'b0;
    logic rst;
    logic in_valid, in_ready, dr_valid, dr_ready;
    logic [LW-1:0]  in_line, dr_line;
    logic [31:0]    in_mask, dr_mask;
    logic [255:0]   in_data, dr_data;

    int vectors = 0;
    int misses  = 0;

    // bench model of the buffer contents
    logic          m_vld  [N];
    logic [LW-1:0] m_line [N];
    logic [31:0]   m_mask [N];
    logic [255:0]  m_data [N];

    always #2 clk = ~clk;

    l0_merge_buffer #(.ENTRIES(N), .LINE_W(LW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_line(in_line), .in_mask(in_mask), .in_data(in_data),
        .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_line(dr_line),
        .dr_mask(dr_mask), .dr_data(dr_data)
    );

    task automatic check(input logic ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
        vectors++;
        if (!ok) begin
            misses++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [255:0] expand(input logic [31:0] m);
        logic [255:0] r;
        for (int k = 0; k < 32; k++) r[8*k +: 8] = m[k] ? 8'hFF : 8'h00;
        return r;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] r;
        for (int k = 0; k < 8; k++) r[32*k +: 32] = $urandom();
        return r;
    endfunction

    // one cycle: drive, compare against the model, clock, update the model
    task automatic step(input logic iv, input logic [LW-1:0] ln, input logic [31:0] mk,
                        input logic [255:0] dt, input logic drr);
        logic any, hit, fre, exp_rdy, full_b;
        int sel, hidx, fidx, cnt_b;
        in_valid = iv; in_line = ln; in_mask = mk; in_data = dt; dr_ready = drr;
        #1;
        any = 0; sel = 0; full_b = 0; cnt_b = -1;
        hit = 0; hidx = 0; fre = 0; fidx = 0;
        for (int i = 0; i < N; i++) begin
            if (m_vld[i]) begin
                logic f; int c;
                f = (m_mask[i] == 32'hFFFFFFFF);
                c = $countones(m_mask[i]);
                if (!any || (f && !full_b) || (f == full_b && c > cnt_b)) begin
                    any = 1; sel = i; full_b = f; cnt_b = c;
                end
                if (m_line[i] == ln) begin hit = 1; hidx = i; end
            end else if (!fre) begin
                fre = 1; fidx = i;
            end
        end
        exp_rdy = hit ? !(any && drr && hidx == sel) : fre;
        check(dr_valid == any, "R7 dr_valid", 256'(dr_valid), 256'(any));
        if (any) begin
            check(dr_line == m_line[sel], "R4 R5 dr_line", 256'(dr_line), 256'(m_line[sel]));
            check(dr_mask == m_mask[sel], "R3 R4 dr_mask", 256'(dr_mask), 256'(m_mask[sel]));
            check(dr_data == m_data[sel], "R2 R3 dr_data", dr_data, m_data[sel]);
        end
        if (iv) check(in_ready == exp_rdy, "R6 R8 R9 in_ready", 256'(in_ready), 256'(exp_rdy));
        @(posedge clk);
        if (any && drr) m_vld[sel] = 0;
        if (iv && exp_rdy) begin
            if (hit) begin
                m_mask[hidx] = m_mask[hidx] | mk;
                m_data[hidx] = (m_data[hidx] & ~expand(mk)) | (dt & expand(mk));
            end else begin
                m_vld[fidx] = 1; m_line[fidx] = ln; m_mask[fidx] = mk;
                m_data[fidx] = dt & expand(mk);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_line[i] = '0; m_mask[i] = '0; m_data[i] = '0;
        end
        rst = 1; in_valid = 0; dr_ready = 0; in_line = '0; in_mask = '0; in_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: empty after reset
        check(dr_valid == 1'b0, "R1 reset dr_valid", 256'(dr_valid), 256'(0));
        step(0, '0, '0, '0, 0);

        // R2 R4: fill all slots with drain held; byte counts 1,2,3,1,2,3,1,2 give ties
        for (int e = 0; e < N; e++)
            step(1, LW'(100 + e), ((32'h1 << ((e % 3) + 1)) - 1) << (4 * e), rnd256(), 0);
        // R6: miss while full, with and without a drain in the same cycle
        step(1, LW'(200), 32'hFF, rnd256(), 0);
        step(1, LW'(201), 32'hFF, rnd256(), 1);
        // R3 R5: complete a partial slot by merging; it must be presented first
        step(1, LW'(104), 32'hFFFFFFFF, rnd256(), 0);
        step(1, LW'(105), 32'h0000FF00, rnd256(), 0);
        // R7: drain everything
        repeat (10) step(0, '0, '0, '0, 1);

        // R8: merge into the slot leaving this cycle stalls, then re-allocates
        step(1, LW'(5), 32'h000000FF, rnd256(), 0);
        step(1, LW'(5), 32'h0000FF00, rnd256(), 1);
        step(1, LW'(5), 32'h0000FF00, rnd256(), 0);
        repeat (2) step(0, '0, '0, '0, 1);

        // R9: merge into one slot while another drains
        step(1, LW'(7), 32'h0000FFFF, rnd256(), 0);
        step(1, LW'(8), 32'h00000001, rnd256(), 0);
        step(1, LW'(8), 32'h00000002, rnd256(), 1);
        repeat (3) step(0, '0, '0, '0, 1);

        // sweep over a small line space with mixed mask shapes
        for (int c = 0; c < 4000; c++) begin
            logic [31:0] mk;
            int kind;
            kind = $urandom_range(0, 3);
            case (kind)
                0: mk = 32'hFFFFFFFF;
                1: mk = 32'hFF << (8 * $urandom_range(0, 3));
                2: mk = $urandom();
                default: mk = 32'h1 << $urandom_range(0, 31);
            endcase
            step(1'($urandom_range(0, 3) != 0), LW'($urandom_range(0, 5)), mk, rnd256(),
                 1'($urandom_range(0, 2) == 0));
        end
        repeat (10) step(0, '0, '0, '0, 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule